// File: doc/BRIEF.md
# ADC Level Monitor with Coarse and Fine Thresholds

This block sits beside a pipelined ADC and produces quick level indicators, used to switch gain or to insert an attenuator before the converter is driven past its range. Each clock it takes two inputs. The first is a 3-bit coarse magnitude code that the converter produces early in its pipeline. The second is the final signed output sample.

From these inputs it derives four flags. The coarse upper flag has low latency and a minimum-hold rule. The fine upper and fine lower flags compare at full resolution. The overrange flag marks a sample that sits at either rail code, after a fixed pipeline delay.

A 4-bit fast-detect bus carries a subset of these results. The mode register chooses which results appear on the bus and which bits carry them. Software loads the mode, the coarse threshold and the two fine thresholds through a simple write strobe.

Top module: `level_monitor`

## Requirements
- R1: While reset is high, and at the first edge after reset, all flags and the fast-detect bus are 0. Reset also clears every register: mode 000, coarse threshold 0, fine upper threshold 0, fine lower threshold 0.
- R2: A write with wr_en high stores wr_data at the following addresses: address 0 stores the mode in bits [2:0], address 1 the coarse threshold in bits [2:0], address 2 the fine upper threshold, and address 3 the fine lower threshold. A stored value first applies to the sample presented at the clock edge after the write edge.
- R3: coarse_up rises two clock edges after the edge that samples a coarse code strictly greater than the coarse threshold. A code equal to the threshold does not assert it.
- R4: Once coarse_up is high, it stays high for at least two cycles. It stays high longer for as long as the code remains above the threshold.
- R5: The sample magnitude is the absolute value of the two's-complement sample, left-aligned to 13 bits. With the default 10-bit sample this means |s| shifted left by 4. The most negative code saturates to the largest positive magnitude, 511 shifted left by 4, which equals 8176.
- R6: fine_up is high one edge after a sample whose magnitude is strictly greater than the fine upper threshold.
- R7: fine_lo is high one edge after a sample whose magnitude is strictly less than the fine lower threshold.
- R8: ovr_flag pulses high for one cycle, 12 edges after a sample equal to the most positive or the most negative code.
- R9: In mode 001, fd_bus[3:1] shows the coarse code delayed by 6 edges, and fd_bus[0] is 0.
- R10: In modes 010 and 011, fd_bus[3:2] shows the top two bits of the coarse code delayed by 6 edges. Mode 010 puts coarse_up on fd_bus[1] and 0 on fd_bus[0]. Mode 011 puts fine_up on fd_bus[1] and fine_lo on fd_bus[0].
- R11: Mode 100 drives fd_bus = {0, 0, fine_up, fine_lo}. Mode 101 drives fd_bus = {coarse_up, 0, fine_up, fine_lo}.
- R12: Mode 000 and the reserved modes 110 and 111 drive fd_bus to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sample clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 2 | Register select |
| wr_data | input | 13 | Register write value |
| fm_code | input | 3 | Coarse magnitude code from the early pipeline |
| sample | input | 10 | Final two's-complement sample |
| ovr_flag | output | 1 | Rail sample seen 12 edges earlier |
| coarse_up | output | 1 | Coarse upper threshold flag |
| fine_up | output | 1 | Fine upper threshold flag |
| fine_lo | output | 1 | Fine lower threshold flag |
| fd_bus | output | 4 | Fast-detect bus, packed according to the mode |

## Verification
The coarse upper flag and the fine upper flag come from different inputs and have different latencies, yet in mode 101 both drive the fast-detect bus in the same cycle. The bench holds a coarse code above its threshold while the sample magnitude sits above the fine upper threshold, until both flags are settled. It then expects fd_bus to be 1010, and it reads each flag pin on its own as well. Mode 100 is then checked with the same inputs, to confirm that only the fine bit remains set.

// File: rtl/lm_pkg.sv
package lm_pkg;
   typedef enum logic [2:0] {
      FD_OFF       = 3'd0,
      FD_MAG3      = 3'd1,
      FD_MAG2_CU   = 3'd2,
      FD_MAG2_FINE = 3'd3,
      FD_FINE      = 3'd4,
      FD_ALL       = 3'd5
   } fd_mode_e;

   localparam logic [1:0] A_MODE = 2'd0;
   localparam logic [1:0] A_CTHR = 2'd1;
   localparam logic [1:0] A_FUT  = 2'd2;
   localparam logic [1:0] A_FLT  = 2'd3;
endpackage

// File: rtl/lm_delay.sv
module lm_delay #(
   parameter int W     = 1,
   parameter int DEPTH = 1
) (
   input  logic         clk,
   input  logic         rst,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   generate
      if (DEPTH == 0) begin : g_wire
         assign q = d;
      end else begin : g_pipe
         logic [W-1:0] stg [DEPTH];
         always_ff @(posedge clk) begin
            if (rst) begin
               stg <= '{default: '0};
            end else begin
               stg[0] <= d;
               for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
            end
         end
         assign q = stg[DEPTH-1];
      end
   endgenerate
endmodule

// File: rtl/lm_regs.sv
module lm_regs #(
   parameter int FM_W  = 3,
   parameter int MAG_W = 13
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [MAG_W-1:0] wr_data,
   output logic [2:0]       mode_q,
   output logic [FM_W-1:0]  cthr_q,
   output logic [MAG_W-1:0] fut_q,
   output logic [MAG_W-1:0] flt_q
);
   import lm_pkg::*;

   always_ff @(posedge clk) begin
      if (rst) begin
         mode_q <= '0;
         cthr_q <= '0;
         fut_q  <= '0;
         flt_q  <= '0;
      end else if (wr_en) begin
         case (wr_addr)
            A_MODE:  mode_q <= wr_data[2:0];
            A_CTHR:  cthr_q <= wr_data[FM_W-1:0];
            A_FUT:   fut_q  <= wr_data;
            default: flt_q  <= wr_data;
         endcase
      end
   end
endmodule

// File: rtl/lm_coarse.sv
module lm_coarse #(
   parameter int FM_W = 3,
   parameter int HOLD = 2
) (
   input  logic            clk,
   input  logic            rst,
   input  logic [FM_W-1:0] code,
   input  logic [FM_W-1:0] thr,
   output logic            flag
);
   localparam int CNT_W = (HOLD > 2) ? $clog2(HOLD) : 1;

   generate
      if (HOLD < 1) begin : g_bad_hold
         $error("lm_coarse: HOLD must be at least 1");
      end
   endgenerate

   logic             gt_q;
   logic [CNT_W-1:0] cnt_q;

   always_ff @(posedge clk) begin
      if (rst) begin
         gt_q  <= 1'b0;
         flag  <= 1'b0;
         cnt_q <= '0;
      end else begin
         gt_q <= (code > thr);
         if (gt_q) begin
            flag <= 1'b1;
            if (!flag)          cnt_q <= CNT_W'(HOLD - 1);
            else if (cnt_q != 0) cnt_q <= cnt_q - 1'b1;
         end else if (cnt_q != 0) begin
            flag  <= 1'b1;
            cnt_q <= cnt_q - 1'b1;
         end else begin
            flag <= 1'b0;
         end
      end
   end
endmodule

// File: rtl/lm_fine.sv
module lm_fine #(
   parameter int SMP_W = 10,
   parameter int MAG_W = 13
) (
   input  logic             clk,
   input  logic             rst,
   input  logic [SMP_W-1:0] sample,
   input  logic [MAG_W-1:0] fut,
   input  logic [MAG_W-1:0] flt,
   output logic [MAG_W-1:0] mag,
   output logic             rail,
   output logic             up,
   output logic             lo
);
   localparam int ABS_W = SMP_W - 1;
   localparam int PAD   = MAG_W - ABS_W;
   localparam logic [SMP_W-1:0] S_MIN = {1'b1, {ABS_W{1'b0}}};
   localparam logic [SMP_W-1:0] S_MAX = {1'b0, {ABS_W{1'b1}}};

   logic [SMP_W-1:0] neg;
   logic [ABS_W-1:0] absv;

   always_comb begin
      neg = -sample;
      if (sample == S_MIN)    absv = '1;
      else if (sample[SMP_W-1]) absv = neg[ABS_W-1:0];
      else                    absv = sample[ABS_W-1:0];
   end

   generate
      if (PAD == 0) begin : g_exact
         assign mag = absv;
      end else begin : g_align
         assign mag = {absv, {PAD{1'b0}}};
      end
   endgenerate

   assign rail = (sample == S_MIN) || (sample == S_MAX);

   always_ff @(posedge clk) begin
      if (rst) begin
         up <= 1'b0;
         lo <= 1'b0;
      end else begin
         up <= (mag > fut);
         lo <= (mag < flt);
      end
   end
endmodule

// File: rtl/level_monitor.sv
module level_monitor #(
   parameter int FM_W    = 3,
   parameter int SMP_W   = 10,
   parameter int MAG_W   = 13,
   parameter int FD_LAT  = 6,
   parameter int OVR_LAT = 12,
   parameter int HOLD    = 2
) (
   input  logic             clk,
   input  logic             rst,
   input  logic             wr_en,
   input  logic [1:0]       wr_addr,
   input  logic [MAG_W-1:0] wr_data,
   input  logic [FM_W-1:0]  fm_code,
   input  logic [SMP_W-1:0] sample,
   output logic             ovr_flag,
   output logic             coarse_up,
   output logic             fine_up,
   output logic             fine_lo,
   output logic [3:0]       fd_bus
);
   import lm_pkg::*;

   generate
      if (FM_W != 3) begin : g_bad_fm
         $error("level_monitor: bus packing needs a 3-bit coarse code");
      end
      if (SMP_W - 1 > MAG_W || SMP_W < 2) begin : g_bad_smp
         $error("level_monitor: sample magnitude wider than MAG_W");
      end
   endgenerate

   logic [2:0]       mode_q;
   logic [FM_W-1:0]  cthr_q;
   logic [MAG_W-1:0] fut_q, flt_q, mag;
   logic             rail;
   logic [FM_W-1:0]  fm_late;

   lm_regs #(.FM_W(FM_W), .MAG_W(MAG_W)) u_regs (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .mode_q(mode_q), .cthr_q(cthr_q), .fut_q(fut_q), .flt_q(flt_q)
   );

   lm_coarse #(.FM_W(FM_W), .HOLD(HOLD)) u_coarse (
      .clk(clk), .rst(rst), .code(fm_code), .thr(cthr_q), .flag(coarse_up)
   );

   lm_fine #(.SMP_W(SMP_W), .MAG_W(MAG_W)) u_fine (
      .clk(clk), .rst(rst), .sample(sample), .fut(fut_q), .flt(flt_q),
      .mag(mag), .rail(rail), .up(fine_up), .lo(fine_lo)
   );

   lm_delay #(.W(FM_W), .DEPTH(FD_LAT)) u_fm_dly (
      .clk(clk), .rst(rst), .d(fm_code), .q(fm_late)
   );

   lm_delay #(.W(1), .DEPTH(OVR_LAT)) u_ovr_dly (
      .clk(clk), .rst(rst), .d(rail), .q(ovr_flag)
   );

   always_comb begin
      case (mode_q)
         FD_MAG3:      fd_bus = {fm_late, 1'b0};
         FD_MAG2_CU:   fd_bus = {fm_late[2:1], coarse_up, 1'b0};
         FD_MAG2_FINE: fd_bus = {fm_late[2:1], fine_up, fine_lo};
         FD_FINE:      fd_bus = {2'b00, fine_up, fine_lo};
         FD_ALL:       fd_bus = {coarse_up, 1'b0, fine_up, fine_lo};
         default:      fd_bus = 4'b0000;
      endcase
   end
endmodule

// File: rtl/lm_chk.sv
module lm_chk #(
   parameter int FM_W    = 3,
   parameter int MAG_W   = 13,
   parameter int OVR_LAT = 12
) (
   input logic             clk,
   input logic             rst,
   input logic [FM_W-1:0]  fm_code,
   input logic [FM_W-1:0]  cthr,
   input logic [MAG_W-1:0] mag,
   input logic [MAG_W-1:0] fut,
   input logic [2:0]       mode,
   input logic             coarse_up,
   input logic             fine_up,
   input logic             ovr,
   input logic [3:0]       fd
);
   logic [15:0] since;
   always_ff @(posedge clk) begin
      if (rst)                since <= '0;
      else if (since != '1)   since <= since + 1'b1;
   end

   // R3
   coarse_latency_chk: assert property (@(posedge clk) disable iff (rst)
      (since >= 2 && $past(fm_code > cthr, 2)) |-> coarse_up);

   // R4
   coarse_hold_chk: assert property (@(posedge clk) disable iff (rst)
      $rose(coarse_up) |=> coarse_up);

   // R6
   fine_up_chk: assert property (@(posedge clk) disable iff (rst)
      (since >= 1) |-> (fine_up == $past(mag > fut)));

   // R8
   ovr_fill_chk: assert property (@(posedge clk) disable iff (rst)
      ovr |-> (since >= OVR_LAT));

   // R12
   fd_quiet_chk: assert property (@(posedge clk) disable iff (rst)
      (mode == 3'd0 || mode > 3'd5) |-> (fd == 4'b0000));
endmodule

bind level_monitor lm_chk #(.FM_W(FM_W), .MAG_W(MAG_W), .OVR_LAT(OVR_LAT)) u_chk (
   .clk(clk), .rst(rst), .fm_code(fm_code), .cthr(cthr_q), .mag(mag), .fut(fut_q),
   .mode(mode_q), .coarse_up(coarse_up), .fine_up(fine_up), .ovr(ovr_flag), .fd(fd_bus)
);

// File: tb/tb_level_monitor.sv
module tb_level_monitor;
   logic              clk = 1'b0;
   logic              rst;
   logic              wr_en;
   logic [1:0]        wr_addr;
   logic [12:0]       wr_data;
   logic [2:0]        fm_code;
   logic signed [9:0] sample;
   logic              ovr_flag, coarse_up, fine_up, fine_lo;
   logic [3:0]        fd_bus;

   int total = 0;
   int fails = 0;
   bit done  = 0;

   always #2.5 clk = ~clk;

   level_monitor dut (
      .clk(clk), .rst(rst), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
      .fm_code(fm_code), .sample(sample), .ovr_flag(ovr_flag), .coarse_up(coarse_up),
      .fine_up(fine_up), .fine_lo(fine_lo), .fd_bus(fd_bus)
   );

   task automatic tick();
      @(posedge clk);
      #1;
   endtask

   task automatic chk(string req, logic [15:0] got, logic [15:0] exp);
      total++;
      if (got !== exp) begin
         fails++;
         $display("FAIL %s: got %0h expected %0h", req, got, exp);
      end
   endtask

   task automatic wr(logic [1:0] a, logic [12:0] d);
      wr_en = 1'b1; wr_addr = a; wr_data = d;
      tick();
      wr_en = 1'b0;
   endtask

   task automatic flush(int n);
      for (int i = 0; i < n; i++) tick();
   endtask

   task automatic t_reset();
      rst = 1'b1; wr_en = 1'b0; wr_addr = '0; wr_data = '0;
      fm_code = 3'd7; sample = 10'sd511;
      flush(3);
      chk("R1 flags in reset", {12'd0, ovr_flag, coarse_up, fine_up, fine_lo}, 16'd0);
      chk("R1 bus in reset", {12'd0, fd_bus}, 16'd0);
      fm_code = 3'd0; sample = 10'sd0;
      tick();
      rst = 1'b0;
      tick();
      chk("R1 flags after reset", {12'd0, ovr_flag, coarse_up, fine_up, fine_lo}, 16'd0);
      chk("R1 bus after reset", {12'd0, fd_bus}, 16'd0);
   endtask

   task automatic t_coarse();
      wr(2'd1, 13'd3);
      fm_code = 3'd3; flush(3);
      chk("R3 equal code no flag", {15'd0, coarse_up}, 16'd0);
      fm_code = 3'd4; tick();
      chk("R3 not yet after one edge", {15'd0, coarse_up}, 16'd0);
      fm_code = 3'd0; tick();
      chk("R3 flag after two edges", {15'd0, coarse_up}, 16'd1);
      tick();
      chk("R4 minimum hold", {15'd0, coarse_up}, 16'd1);
      tick();
      chk("R4 release after hold", {15'd0, coarse_up}, 16'd0);
      fm_code = 3'd5; tick(); tick();
      chk("R4 long exceed start", {15'd0, coarse_up}, 16'd1);
      tick(); tick();
      fm_code = 3'd0; tick();
      chk("R4 extended while above", {15'd0, coarse_up}, 16'd1);
      tick();
      chk("R4 drop after exceed ends", {15'd0, coarse_up}, 16'd0);
   endtask

   task automatic t_fine();
      wr(2'd2, 13'd1600);
      wr(2'd3, 13'd800);
      sample = 10'sd100; tick();
      chk("R6 equal magnitude not above", {14'd0, fine_up, fine_lo}, 16'd0);
      sample = 10'sd101; tick();
      chk("R6 above upper", {15'd0, fine_up}, 16'd1);
      sample = -10'sd101; tick();
      chk("R5 negative magnitude above upper", {15'd0, fine_up}, 16'd1);
      sample = 10'sd50; tick();
      chk("R7 equal magnitude not below", {14'd0, fine_up, fine_lo}, 16'd0);
      sample = 10'sd49; tick();
      chk("R7 below lower", {15'd0, fine_lo}, 16'd1);
      sample = -10'sd49; tick();
      chk("R7 negative below lower", {15'd0, fine_lo}, 16'd1);
   endtask

   task automatic t_saturate();
      wr(2'd2, 13'd8175);
      sample = -10'sd512; tick();
      chk("R5 most negative saturates", {15'd0, fine_up}, 16'd1);
      sample = 10'sd511; tick();
      chk("R5 full positive", {15'd0, fine_up}, 16'd1);
      wr(2'd2, 13'd8176);
      chk("R2 old threshold at write edge", {15'd0, fine_up}, 16'd1);
      tick();
      chk("R2 new threshold next edge", {15'd0, fine_up}, 16'd0);
      sample = -10'sd512; tick();
      chk("R5 saturated equals 8176", {15'd0, fine_up}, 16'd0);
      sample = 10'sd0;
   endtask

   task automatic t_ovr();
      sample = 10'sd0; flush(15);
      chk("R8 idle", {15'd0, ovr_flag}, 16'd0);
      sample = 10'sd511; tick();
      sample = 10'sd0; flush(10);
      chk("R8 not before 12 edges", {15'd0, ovr_flag}, 16'd0);
      tick();
      chk("R8 positive rail at 12 edges", {15'd0, ovr_flag}, 16'd1);
      tick();
      chk("R8 single cycle", {15'd0, ovr_flag}, 16'd0);
      sample = -10'sd512; tick();
      sample = 10'sd0; flush(11);
      chk("R8 negative rail at 12 edges", {15'd0, ovr_flag}, 16'd1);
      sample = 10'sd510; flush(13);
      chk("R8 near rail no flag", {15'd0, ovr_flag}, 16'd0);
      sample = 10'sd0;
   endtask

   task automatic t_mag_bus();
      logic [2:0] seq [14];
      wr(2'd1, 13'd7);
      wr(2'd0, 13'd1);
      for (int i = 0; i < 14; i++) seq[i] = (i < 8) ? 3'(7 - i) : 3'd0;
      for (int i = 0; i < 14; i++) begin
         fm_code = seq[i];
         tick();
         if (i >= 5) chk("R9 code on bus after 6 edges", {12'd0, fd_bus}, {12'd0, seq[i-5], 1'b0});
      end
   endtask

   task automatic t_pack();
      wr(2'd1, 13'd3);
      wr(2'd0, 13'd2);
      fm_code = 3'd6; sample = 10'sd0; flush(8);
      chk("R10 mode 010 packing", {12'd0, fd_bus}, 16'b1110);
      wr(2'd0, 13'd3); tick();
      chk("R10 mode 011 packing", {12'd0, fd_bus}, 16'b1101);
      wr(2'd0, 13'd4); tick();
      chk("R11 mode 100 lower only", {12'd0, fd_bus}, 16'b0001);
      wr(2'd2, 13'd1000);
      wr(2'd0, 13'd5);
      sample = 10'sd300; flush(3);
      chk("R11 mode 101 coarse and fine together", {12'd0, fd_bus}, 16'b1010);
      chk("R3 coarse pin in joint cycle", {15'd0, coarse_up}, 16'd1);
      chk("R6 fine pin in joint cycle", {15'd0, fine_up}, 16'd1);
      wr(2'd0, 13'd4); tick();
      chk("R11 mode 100 drops coarse", {12'd0, fd_bus}, 16'b0010);
      wr(2'd0, 13'd6); tick();
      chk("R12 reserved 110", {12'd0, fd_bus}, 16'd0);
      wr(2'd0, 13'd7); tick();
      chk("R12 reserved 111", {12'd0, fd_bus}, 16'd0);
      wr(2'd0, 13'd0); tick();
      chk("R12 mode 000", {12'd0, fd_bus}, 16'd0);
   endtask

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         fails++;
         $display("FAIL watchdog: got hang expected completion");
         $display("%0d/%0d checks passed", total - fails, total);
         $finish;
      end
   end

   initial begin
      t_reset();
      t_coarse();
      t_fine();
      t_saturate();
      t_ovr();
      t_mag_bus();
      t_pack();
      done = 1;
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
   end
endmodule